// File: doc/BRIEF.md
# Float32 to R11G11B10 Packer

This block converts three single-precision floating-point colour components into one 32-bit word of three unsigned small floats. Red and green each become an 11-bit value with a 5-bit exponent above a 6-bit mantissa. Blue becomes a 10-bit value with a 5-bit exponent above a 5-bit mantissa. The three channels are converted independently and in parallel. Each conversion discards the sign, truncates the mantissa toward zero and clamps overflow to the largest finite code. Infinities and NaNs map to fixed codes.

Operands arrive on a valid/ready input that carries the three floats together. The packed word leaves through a valid/ready output stage that holds one registered word. A new triple can be taken on every cycle in which the output side is ready. This makes the block a drop-in stage in a pixel pipeline that writes packed HDR colour.

Top module: `f32PackR11G11B10`

## Requirements
- R1: Bit positions of the output word: red at bits 10:0, green at bits 21:11, blue at bits 31:22. In each field the exponent occupies the upper 5 bits and the mantissa the lower bits (6 for red and green, 5 for blue). A normal input with unbiased exponent E in -14..15 gives exponent field E+15. Its mantissa field is the leading fraction bits of the input.
- R2: Rounding is toward zero. Fraction bits below the kept mantissa width are dropped, so an input of 1.99999988 gives an all-ones mantissa with exponent field 15.
- R3: A positive finite input of 65536.0 or more gives exponent field 30 and an all-ones mantissa. It never gives infinity.
- R4: Every negative input gives an all-zero field. This covers negative finite values, negative zero and negative infinity.
- R5: Positive infinity gives exponent field 31 with a zero mantissa.
- R6: A NaN of either sign gives exponent field 31. Its mantissa has only the most significant bit set.
- R7: A positive input below 2^-14 and at or above the float32 normal range gives exponent field 0. Its mantissa is floor(value * 2^(14+mantissa width)). For example, 2^-15 gives red mantissa 32 and blue mantissa 16.
- R8: Positive zero and float32 denormal inputs give an all-zero field.
- R9: Handshake. inReady is high whenever outValid is low or outReady is high. An accepted input appears on outWord with outValid high one cycle later. While outValid is high and outReady is low, outValid and outWord hold.
- R10: While reset is asserted, and after reset is released with no input accepted, outValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input triple is valid |
| inReady | output | 1 | Block can accept the triple this cycle |
| redIn | input | 32 | Red component, IEEE-754 single |
| greenIn | input | 32 | Green component, IEEE-754 single |
| blueIn | input | 32 | Blue component, IEEE-754 single |
| outValid | output | 1 | outWord holds a packed result |
| outReady | input | 1 | Consumer takes outWord this cycle |
| outWord | output | 32 | Packed blue/green/red small floats |

## Verification
The bench targets the edges of the conversion. The largest finite value and the first value past it must not become infinity. The smallest normal and the denormal band just below it must not be flushed or off by one shift. NaN must not collapse into infinity, and negative infinity and negative zero must not keep a sign or produce infinity. Directed triples place these cases on different channels, so that a swapped field offset or the wrong mantissa width for blue corrupts a neighbouring field. A random phase with random stalls covers the handshake, where a design that overwrote its held word or dropped valid under back-pressure would lose or duplicate results.

// File: rtl/f32PackPkg.sv
package f32PackPkg;
  localparam int EXP_W    = 5;
  localparam int CH_COUNT = 3;
  localparam int WORD_W   = 32;
  // channel order red, green, blue; offsets fixed by the packed layout
  localparam int CH_MANT [CH_COUNT] = '{6, 6, 5};
  localparam int CH_LSB  [CH_COUNT] = '{0, 11, 22};

  typedef struct packed {
    logic load;
  } packStrobe_t;
endpackage

// File: rtl/sfConvert.sv
module sfConvert #(
  parameter int MANT_W = 6,
  parameter int EXP_W  = 5
) (
  input  logic [31:0]             fIn,
  output logic [MANT_W+EXP_W-1:0] code
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP = (1 << EXP_W) - 1;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [EXP_W-1:0] EXP_SAT  = EXP_ONES - 1'b1;
  localparam logic [MANT_W-1:0] MANT_ONES = '1;
  localparam logic [MANT_W-1:0] QUIET = {1'b1, {(MANT_W-1){1'b0}}};

  logic        sgn;
  logic [7:0]  expIn;
  logic [22:0] frac;
  logic [23:0] sig;
  int          rebias;
  int          sh;

  assign sgn   = fIn[31];
  assign expIn = fIn[30:23];
  assign frac  = fIn[22:0];
  assign sig   = {1'b1, frac};

  always_comb begin
    code   = '0;
    rebias = int'(expIn) - 127 + BIAS;
    sh     = 0;
    if (expIn == 8'hFF) begin
      if (frac != '0)
        code = {EXP_ONES, QUIET};
      else if (!sgn)
        code = {EXP_ONES, {MANT_W{1'b0}}};
    end else if (sgn || expIn == 8'h00) begin
      code = '0;
    end else if (rebias >= EXP_TOP) begin
      code = {EXP_SAT, MANT_ONES};
    end else if (rebias >= 1) begin
      code = {rebias[EXP_W-1:0], frac[22 -: MANT_W]};
    end else begin
      sh = 1 - rebias + (23 - MANT_W);
      if (sh < 24)
        code = {{EXP_W{1'b0}}, MANT_W'(sig >> sh)};
    end
  end
endmodule

// File: rtl/packDatapath.sv
module packDatapath
  import f32PackPkg::*;
(
  input  logic              clk,
  input  packStrobe_t       strobe,
  input  logic [31:0]       redIn,
  input  logic [31:0]       greenIn,
  input  logic [31:0]       blueIn,
  output logic [WORD_W-1:0] outWord
);
  logic [31:0]       chIn [CH_COUNT];
  logic [WORD_W-1:0] wordNext;

  assign chIn[0] = redIn;
  assign chIn[1] = greenIn;
  assign chIn[2] = blueIn;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_ch
    sfConvert #(
      .MANT_W(CH_MANT[ch]),
      .EXP_W (EXP_W)
    ) u_conv (
      .fIn (chIn[ch]),
      .code(wordNext[CH_LSB[ch] +: CH_MANT[ch] + EXP_W])
    );
  end

  always_ff @(posedge clk) begin
    if (strobe.load) outWord <= wordNext;
  end
endmodule

// File: rtl/packControl.sv
module packControl
  import f32PackPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output packStrobe_t strobe
);
  assign inReady     = !outValid || outReady;
  assign strobe.load = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN)        outValid <= 1'b0;
    else if (inReady) outValid <= inValid;
  end
endmodule

// File: rtl/f32PackR11G11B10.sv
module f32PackR11G11B10
  import f32PackPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] redIn,
  input  logic [31:0] greenIn,
  input  logic [31:0] blueIn,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outWord
);
  packStrobe_t strobe;

  packControl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  packDatapath u_dp (
    .clk    (clk),
    .strobe (strobe),
    .redIn  (redIn),
    .greenIn(greenIn),
    .blueIn (blueIn),
    .outWord(outWord)
  );
endmodule

// File: rtl/packChecker.sv
module packChecker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic [31:0] redIn,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outWord
);
  // R9: stalled output keeps its word and valid flag
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outWord));

  // R9: accepted input produces a valid output next cycle
  a_r9_accept: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  // R9: an empty output stage never back-pressures
  a_r9_ready: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  // R4: negative non-NaN red gives a zero red field
  a_r4_neg_red: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && redIn[31] && !(redIn[30:23] == 8'hFF && redIn[22:0] != 0)
    |=> outWord[10:0] == 11'h000);

  // R6: a red field with exponent 31 is either infinity or the quiet NaN code
  a_r6_red_special: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outWord[10:6] == 5'h1F |-> outWord[5:0] == 6'h00 || outWord[5:0] == 6'h20);

  // R6: same for the narrower blue field
  a_r6_blue_special: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outWord[31:27] == 5'h1F |-> outWord[26:22] == 5'h00 || outWord[26:22] == 5'h10);

  // R10: reset clears valid
  a_r10_reset: assert property (@(posedge clk) !rstN |=> !outValid);
endmodule

bind f32PackR11G11B10 packChecker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .redIn   (redIn),
  .outValid(outValid),
  .outReady(outReady),
  .outWord (outWord)
);

// File: tb/sim_f32PackR11G11B10.sv
module sim_f32PackR11G11B10;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] redIn = '0, greenIn = '0, blueIn = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outWord;

  int errors = 0;
  int checks = 0;
  logic        modelValid = 1'b0;
  logic [31:0] modelWord = '0;
  string       modelTag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  f32PackR11G11B10 u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .redIn(redIn), .greenIn(greenIn), .blueIn(blueIn),
    .outValid(outValid), .outReady(outReady), .outWord(outWord)
  );

  // behavioural reference for one field, via real arithmetic
  function automatic int refField(logic [31:0] b, int mw);
    logic [63:0] dbits;
    real v;
    if (b[30:23] == 8'hFF) begin
      if (b[22:0] != 0) return (31 << mw) | (1 << (mw - 1));
      return b[31] ? 0 : (31 << mw);
    end
    if (b[31] || b[30:23] == 0) return 0;
    dbits = {1'b0, 11'(int'(b[30:23]) - 127 + 1023), b[22:0], 29'b0};
    v = $bitstoreal(dbits);
    if (v >= 65536.0) return (30 << mw) | ((1 << mw) - 1);
    for (int k = 15; k >= -14; k--) begin
      if (v >= 2.0 ** k)
        return ((k + 15) << mw) | $rtoi((v / (2.0 ** k) - 1.0) * (2.0 ** mw));
    end
    return $rtoi(v * (2.0 ** (14 + mw)));
  endfunction

  function automatic logic [31:0] refWord(logic [31:0] r, logic [31:0] g, logic [31:0] bl);
    int rv, gv, bv;
    rv = refField(r, 6);
    gv = refField(g, 6);
    bv = refField(bl, 5);
    return (32'(bv) << 22) | (32'(gv) << 11) | 32'(rv);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // at a falling edge: compare, then drive the next cycle and advance the model
  task automatic cycle(logic v, logic rdy, logic [31:0] r, logic [31:0] g,
                       logic [31:0] bl, string tag);
    logic mReady;
    @(negedge clk);
    check({modelTag, " valid"}, 32'(outValid), 32'(modelValid));
    check("R9 ready", 32'(inReady), 32'(!modelValid || outReady));
    if (modelValid) check({modelTag, " word"}, outWord, modelWord);
    inValid = v; outReady = rdy; redIn = r; greenIn = g; blueIn = bl;
    mReady = !modelValid || rdy;
    if (mReady) begin
      modelValid = v;
      if (v) begin
        modelWord = refWord(r, g, bl);
        modelTag  = tag;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R10 reset valid", 32'(outValid), 32'h0);
    end
    rstN = 1'b1;
    cycle(0, 1, '0, '0, '0, "R10");
    cycle(0, 0, '0, '0, '0, "R10");
    // R1 normals
    cycle(1, 1, 32'h3F800000, 32'h40490FDB, 32'h3E800000, "R1 normal");
    cycle(1, 1, 32'h38800000, 32'h47000000, 32'h42F60000, "R1 range ends");
    // R2 truncation
    cycle(1, 1, 32'h3FFFFFFF, 32'h3FFDFFFF, 32'h3FFBFFFF, "R2 truncate");
    // R3 saturation
    cycle(1, 1, 32'h47800000, 32'h7F7FFFFF, 32'h477FFFFF, "R3 saturate");
    cycle(1, 1, 32'h477E0000, 32'h477F0000, 32'h477C0000, "R3 near max");
    // R4 negatives
    cycle(1, 1, 32'hBF800000, 32'hFF800000, 32'h80000000, "R4 negative");
    cycle(1, 1, 32'hFF7FFFFF, 32'h80000001, 32'hC7800000, "R4 negative");
    // R5 +inf, R6 NaN
    cycle(1, 1, 32'h7F800000, 32'h7F800000, 32'h7F800000, "R5 inf");
    cycle(1, 1, 32'h7FC00000, 32'hFF800001, 32'h7F800001, "R6 nan");
    cycle(1, 1, 32'hFFFFFFFF, 32'h7F800000, 32'hFFC00000, "R6 nan mix");
    // R7 small-float denormals
    cycle(1, 1, 32'h38000000, 32'h33800000, 32'h38000000, "R7 denorm");
    cycle(1, 1, 32'h387FFFFF, 32'h35800000, 32'h37000000, "R7 denorm");
    cycle(1, 1, 32'h33000000, 32'h34FFFFFF, 32'h36000000, "R7 tiny");
    // R8 zero and float denormals
    cycle(1, 1, 32'h00000000, 32'h00000001, 32'h007FFFFF, "R8 zero");
    // R9 stall holds then releases
    cycle(1, 0, 32'h3F800000, 32'h3F800000, 32'h3F800000, "R9 stall");
    cycle(1, 0, 32'h40000000, 32'h40000000, 32'h40000000, "R9 stall");
    cycle(1, 0, 32'h40000000, 32'h40000000, 32'h40000000, "R9 stall");
    cycle(1, 1, 32'h40000000, 32'h40000000, 32'h40000000, "R9 release");
    cycle(0, 1, '0, '0, '0, "R9");
    // random phase with random back-pressure
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] f [3];
      for (int c = 0; c < 3; c++) begin
        if ($urandom % 4 == 0) f[c] = $urandom;
        else f[c] = {1'($urandom % 8 == 0), 8'(95 + $urandom % 55), 23'($urandom)};
      end
      cycle(1'($urandom % 4 != 0), 1'($urandom % 3 != 0), f[0], f[1], f[2], "R9 random");
    end
    cycle(0, 1, '0, '0, '0, "R9");
    cycle(0, 1, '0, '0, '0, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule